// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Slave

This block is a two-wire serial slave that fronts a small byte memory held inside it. A bus master addresses it with a 7-bit device address. A write sends two word-address bytes, high byte first, and then any number of data bytes. A read returns bytes starting from an internal address latch. That latch advances by one for every byte moved in either direction, and it rolls over to zero past the last location.

A master can use the latch in three ways. It can write a stream of bytes. It can read on from wherever the last access left off. It can perform a selective read: a write-mode address phase sets the latch, and a repeated Start then begins a read. The slave releases the data line cleanly however the master ends a read. A data byte that is cut short by a Start or Stop is dropped without touching memory.

Both bus lines pass through two-flop synchronizers. Start and Stop are decoded from data-line edges while the clock line is high. The slave moves its own data-line drive only while the clock line is low. The data line is open drain. `sda_oe` enables the slave's driver and `sda_dout` is the level it drives. A driven 1 and a released line both read high on the bus.

Top module: `i2c_mem_slave`

## Requirements
- R1: The first byte after a Start holds the device address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). The slave acknowledges only when bits 7..1 equal DEV_ADDR. On a mismatch it leaves SDA released for the acknowledge clock and stays released until the next Start.
- R2: In a write transaction the slave acknowledges the device address, both word-address bytes and every data byte by pulling SDA low during the ninth clock of that byte.
- R3: The word address arrives as two bytes, high byte first. Only its low ADDR_W bits select a location, and the upper bits are ignored.
- R4: Consecutive data bytes of one write land at consecutive locations, starting at the word address.
- R5: A read that is not preceded by an address phase starts at the latch value, which points one past the last byte written or read.
- R6: Read data is driven MSB first, starting on the clock after the address acknowledge. When the master acknowledges a read byte, the slave sends the next sequential byte.
- R7: The latch wraps from 2^ADDR_W-1 to 0, for reads and for writes.
- R8: A write-mode address phase followed by a repeated Start and a read-mode device address reads from the new word address.
- R9: SDA is released after each of these read endings: a NACK followed by Stop, a NACK followed by Start, a Stop in the ninth clock, and a Start in the ninth clock. The slave also releases SDA on the cycle after any Start or Stop is decoded.
- R10: A Start or Stop that arrives before the eighth bit of a write data byte discards that byte. Memory and the latch are left unchanged.
- R11: The slave enables its driver, and changes the level it drives, only while SCL is low.
- R12: After reset SDA is released and the latch is 0, so a current-address read returns the byte at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Enable for the slave's data-line driver |
| sda_dout | output | 1 | Level driven on the data line while sda_oe is high |

## Verification
A wrong latch value shows up as the wrong byte on the very first read data clock of the next read. A broken wrap or increment is therefore exposed by reading back right after a write that crosses the top of memory. A protocol state that is off by one bit shows within the same byte, as a missing acknowledge or a shifted read byte. A driver left enabled after a read ending shows as `sda_oe` high a few system clocks after the Stop or Start. A write that is not aborted correctly stays hidden until that location is read back.

// File: rtl/i2c_mem_pkg.sv
// Package: shared protocol phase encoding for the I2C memory slave.
// Assumes no other block depends on the numeric values of the phases.
package i2c_mem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,   // not addressed, waiting for Start
        PH_DEV,    // shifting in the device address byte
        PH_AHI,    // shifting in the word address high byte
        PH_ALO,    // shifting in the word address low byte
        PH_WDAT,   // shifting in a write data byte
        PH_ACK,    // slave acknowledge clock
        PH_RDAT,   // shifting out a read data byte
        PH_RACK    // master acknowledge clock of a read byte
    } phase_t;

endpackage

// File: rtl/i2c_line_front.sv
// Module: synchronizes SCL and SDA and decodes bus events.
// Assumes: the system clock runs many times faster than SCL, so a
// single-cycle event pulse per bus edge is enough for the protocol engine.
module i2c_line_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] raw_lines;
    logic [1:0] sync_lines;
    logic       scl_s;
    logic       scl_q;
    logic       sda_q;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Shift the raw line through the synchronizer chain; idle level is high.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw_lines[g]};
        end
        assign sync_lines[g] = chain[SYNC_STAGES-1];
    end

    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_mem_store.sv
// Module: byte storage array, one write port and one asynchronous read port.
// Assumes: contents are not reset; only locations that have been written are
// meaningful to a master.
module i2c_mem_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Store one byte when the protocol engine commits a write.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/i2c_mem_fsm.sv
// Module: protocol engine. Receives the device and word addresses, commits
// write bytes, serves read bytes and owns the auto-incrementing address latch.
// Assumes: event pulses come from i2c_line_front; SCL-high time spans several
// system clocks; SDA drive changes are made on the detected SCL fall.
module i2c_mem_fsm
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              sda_oe,
    output logic              sda_dout
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    phase_t     phase;
    phase_t     after_ack;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] rx_next;
    logic [6:0] tx_sh;
    logic [7:0] addr_hi;
    logic       ack_on;
    logic       m_ack;

    assign rx_next = {rx_sh[6:0], sda_s};

    // Step the bus protocol on each decoded bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            after_ack <= PH_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            addr_hi   <= '0;
            ptr       <= '0;
            ack_on    <= 1'b0;
            m_ack     <= 1'b0;
            sda_oe    <= 1'b0;
            sda_dout  <= 1'b1;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase   <= PH_DEV;
                bit_cnt <= '0;
                ack_on  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_DEV, PH_AHI, PH_ALO, PH_WDAT: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_next;
                            bit_cnt <= bit_cnt + 4'd1;
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                                phase   <= PH_ACK;
                                if (phase == PH_DEV) begin
                                    if (rx_next[7:1] != DEV_ADDR) phase <= PH_IDLE;
                                    after_ack <= rx_next[0] ? PH_RDAT : PH_AHI;
                                end else if (phase == PH_AHI) begin
                                    addr_hi   <= rx_next;
                                    after_ack <= PH_ALO;
                                end else if (phase == PH_ALO) begin
                                    ptr       <= ADDR_W'({addr_hi, rx_next});
                                    after_ack <= PH_WDAT;
                                end else begin
                                    wr_en     <= 1'b1;
                                    wr_addr   <= ptr;
                                    wr_data   <= rx_next;
                                    ptr       <= ptr + ONE;
                                    after_ack <= PH_WDAT;
                                end
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                ack_on   <= 1'b1;
                                sda_oe   <= 1'b1;
                                sda_dout <= 1'b0;
                            end else begin
                                ack_on  <= 1'b0;
                                bit_cnt <= '0;
                                if (after_ack == PH_RDAT) begin
                                    tx_sh    <= rd_data[6:0];
                                    sda_dout <= rd_data[7];
                                    ptr      <= ptr + ONE;
                                    phase    <= PH_RDAT;
                                end else begin
                                    sda_oe <= 1'b0;
                                    phase  <= after_ack;
                                end
                            end
                        end
                    end
                    PH_RDAT: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                        if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RACK;
                            end else begin
                                sda_dout <= tx_sh[6];
                                tx_sh    <= {tx_sh[5:0], 1'b0};
                            end
                        end
                    end
                    PH_RACK: begin
                        if (scl_rise) m_ack <= ~sda_s;
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (m_ack) begin
                                tx_sh    <= rd_data[6:0];
                                sda_dout <= rd_data[7];
                                sda_oe   <= 1'b1;
                                ptr      <= ptr + ONE;
                                phase    <= PH_RDAT;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_mem_slave.sv
// Module: top of the I2C byte-memory slave; wires the line front end, the
// protocol engine and the storage array together.
// Assumes: the pad applies open-drain behaviour (drive only while sda_oe is
// high, and a driven 1 is equivalent to a released line).
module i2c_mem_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic sda_dout
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        rd_data;

    i2c_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_mem_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .sda_oe    (sda_oe),
        .sda_dout  (sda_dout)
    );

    i2c_mem_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
// Module: assertion checker bound to i2c_mem_slave.
// Assumes: SCL low time exceeds the synchronizer plus event latency.
module i2c_mem_slave_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              sda_dout,
    input logic              start_det,
    input logic              stop_det,
    input logic              scl_rise,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] ptr
);

    // R11: the driver is enabled only while SCL is low
    p_oe_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R11: the driven level changes only while SCL is low
    p_dout_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && $past(sda_oe) && (sda_dout != $past(sda_dout))) |-> !scl_i);

    // R9: any Start or Stop releases the line on the next cycle
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe);

    // R4 and R7: each committed byte leaves the latch one past it, wrapping
    p_latch_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == ADDR_W'(wr_addr + ADDR_W'(1))));

    // R10: a byte is only committed on the clock rise that completes it
    p_commit_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_rise));

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .sda_dout  (sda_dout),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ptr       (ptr)
);

// File: tb/sim_i2c_mem_slave.sv
// Bench: bus master tasks keep a reference memory and latch, push each
// expected read byte into a queue, and a monitor compares captured bytes.
module sim_i2c_mem_slave;

    localparam int         ADDR_W = 8;
    localparam logic [6:0] DEV    = 7'h50;
    localparam int         Q      = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_dout;
    wire  sda_line = sda_m & ~(sda_oe & ~sda_dout);

    int checks = 0;
    int failures = 0;

    logic [7:0]        ref_mem [1 << ADDR_W];
    logic [ADDR_W-1:0] ref_ptr = '0;
    logic [7:0]        exp_q [$];
    string             tag_q [$];
    logic [7:0]        got_byte;
    event              got_ev;

    always #4 clk = ~clk;

    i2c_mem_slave #(.DEV_ADDR(DEV), .ADDR_W(ADDR_W)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .sda_dout (sda_dout)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_cond();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, input string tag, input logic exp_ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        read_bit(a);
        check(tag, int'(!a), int'(exp_ack));
    endtask

    task automatic wr_hdr(input logic [15:0] a);
        start_cond();
        send_byte({DEV, 1'b0}, "R2 device ack", 1'b1);
        send_byte(a[15:8], "R2 high address ack", 1'b1);
        send_byte(a[7:0], "R3 low address ack", 1'b1);
        ref_ptr = a[ADDR_W-1:0];
    endtask

    task automatic write_seq(input logic [15:0] a, input int n, input logic [7:0] base);
        wr_hdr(a);
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i), "R4 data ack", 1'b1);
            ref_mem[ref_ptr] = base + 8'(i);
            ref_ptr = ref_ptr + 1'b1;
        end
        stop_cond();
    endtask

    // term: 1 NACK+Stop, 2 NACK+Start, 3 Stop in 9th, 4 Start in 9th
    task automatic read_bytes(input int n, input int term, input string tag);
        logic b;
        logic [7:0] d;
        start_cond();
        send_byte({DEV, 1'b1}, "R1 read device ack", 1'b1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(ref_mem[ref_ptr]);
            tag_q.push_back(tag);
            ref_ptr = ref_ptr + 1'b1;
            for (int k = 7; k >= 0; k--) begin
                read_bit(b);
                d[k] = b;
            end
            got_byte = d;
            ->got_ev;
            if (i < n - 1) send_bit(1'b0);
        end
        case (term)
            1: begin send_bit(1'b1); stop_cond(); end
            2: begin
                send_bit(1'b1); start_cond(); wq();
                check("R9 NACK then Start release", int'(sda_oe), 0);
                send_byte({7'h11, 1'b1}, "R1 other device", 1'b0);
                stop_cond();
            end
            3: stop_cond();
            default: begin
                start_cond(); wq();
                check("R9 Start in ninth clock release", int'(sda_oe), 0);
                stop_cond();
            end
        endcase
        wq();
        check("R9 release after read end", int'(sda_oe), 0);
    endtask

    // Monitor: compare each captured read byte with the queued expectation.
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                check("R6 unexpected read byte", 1, 0);
            end else begin
                check({tag_q.pop_front(), " read data"}, int'(got_byte), int'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12 released after reset", int'(sda_oe), 0);

        // R1: wrong device address gets no acknowledge
        start_cond();
        for (int i = 7; i >= 0; i--) send_bit(logic'(8'h42 >> i));
        read_bit(a);
        check("R1 mismatch no ack", int'(a), 1);
        check("R1 mismatch released", int'(sda_oe), 0);
        stop_cond();

        // R3/R4: upper word-address bits ignored; six bytes at 0x34..0x39
        write_seq(16'h1234, 6, 8'hA0);

        // R8 selective read, R6 sequential, R9 method one
        wr_hdr(16'h0034);
        read_bytes(4, 1, "R8");

        // R5 current-address read continues at 0x38, R9 method two
        read_bytes(1, 2, "R5");
        // R6 continues at 0x39, R9 method three
        read_bytes(1, 3, "R6");

        // R7 wrap across the top of memory, R9 method four
        write_seq(16'h00FE, 3, 8'h11);
        wr_hdr(16'h00FE);
        read_bytes(3, 4, "R7");

        // R10: abort by Stop leaves the byte at 0x10 intact
        write_seq(16'h0010, 2, 8'h5A);
        wr_hdr(16'h0010);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        stop_cond();
        wr_hdr(16'h0010);
        read_bytes(1, 1, "R10 stop abort");

        // R10: abort by Start keeps the latch at 0x11
        wr_hdr(16'h0011);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        read_bytes(1, 1, "R10 start abort");

        // R12: reset clears the latch; current read returns location 0
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        ref_ptr = '0;
        repeat (4) @(negedge clk);
        check("R12 released after second reset", int'(sda_oe), 0);
        read_bytes(1, 1, "R12");

        wq();
        check("R6 all expected bytes seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule